// File: doc/BRIEF.md
# Vector Block-Floating-Point Normalizer

This block scales a column of eight complex fixed-point samples by one shared power of two. A Gram-Schmidt orthogonalizer works better when each column fills its number range. Scaling a whole column by 2^k leaves the orthonormal basis of the decomposition unchanged, so this block can sit directly in front of one. Samples arrive one per clock with a valid flag, and a last flag marks the eighth element. While the vector streams in, the block folds the magnitude of every real and imaginary part into a running OR. In that OR, each set bit also sets every bit below it, so the register always holds a solid run of ones that ends at the largest magnitude seen.

When the last element is accepted, a three-level binary tree over that register picks the left shift. The shift is the number of steps that brings the largest magnitude up to a fixed lower exponent bound, capped at seven. The vector is held in one half of a two-bank buffer. It is played back over the next eight clocks, with every element shifted by the chosen amount, while the following vector fills the other bank. One vector every eight clocks can be sustained. The control is a two-state machine. In ST_IDLE nothing is played. The "vector closed" transition (a valid element with the last flag set) moves ST_IDLE to ST_PLAY, or restarts ST_PLAY at element 0 with the new bank and shift. The "drained" transition returns ST_PLAY to ST_IDLE after the eighth output element when no new vector has closed.

Top module: `bfp_vector_normalizer`

## Requirements
- R1: While rst_n is low, and on the first cycles after it is released with no input, out_valid and out_last are 0.
- R2: If the largest magnitude over the vector is 2048 or more (any of magnitude bits 13..11 set), out_shift is 0 and the samples pass unchanged.
- R3: If the most significant set bit of the largest magnitude is bit k, with k from 5 to 10, out_shift equals 11 - k.
- R4: If the largest magnitude is below 32, including an all-zero vector, out_shift is 7.
- R5: Each output element equals its input element multiplied by 2^out_shift, in both the real and the imaginary part. One shift value is used for all eight elements. A shifted sample never reaches a magnitude of 4096.
- R6: The largest magnitude is taken over the absolute values of both the real and the imaginary parts. Negative values count by their absolute value, and the code -8192 counts as 8191.
- R7: The first output element appears on the cycle after the element carrying in_last is accepted. out_valid stays high for exactly eight consecutive cycles, and out_last is high on the eighth.
- R8: The running OR starts empty for every vector, so a small vector that follows a large one gets its own, larger shift.
- R9: When vectors arrive back to back, the output stays valid without a gap, and each vector keeps its own shift.
- R10: A cycle with in_valid low is ignored, whatever in_re, in_im and in_last hold: it neither adds to the magnitude, nor stores an element, nor closes a vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input element present this cycle |
| in_last | input | 1 | Input element is the last (eighth) of its vector |
| in_re | input | 14 | Real part of the input element, two's complement |
| in_im | input | 14 | Imaginary part of the input element, two's complement |
| out_valid | output | 1 | Output element present this cycle |
| out_last | output | 1 | Output element is the last of its vector |
| out_re | output | 14 | Real part of the scaled element |
| out_im | output | 14 | Imaginary part of the scaled element |
| out_shift | output | 3 | Left shift applied to the current output vector |

## Verification
The two functions that can fall in one cycle are the closing of a new vector and the playback of the previous vector's final element. In that cycle the running OR is cleared and a new shift and bank are loaded, while the old shift is still on the outputs. The bench provokes this by sending a vector of large samples and then, with no idle cycle, a vector of tiny samples. It judges the result by sixteen consecutive valid outputs, with out_last only on the eighth and sixteenth. The first eight carry shift 0 and the last eight carry shift 7, each with correctly scaled data.

// File: rtl/bfp_pkg.sv
`timescale 1ns/1ps
package bfp_pkg;
    // Depth of the shift-selection tree fixes the shift range.
    localparam int SHIFT_W   = 3;
    localparam int MAX_SHIFT = (1 << SHIFT_W) - 1;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_PLAY = 1'b1
    } bfp_state_e;
endpackage

// File: rtl/bfp_mag_accum.sv
`timescale 1ns/1ps
module bfp_mag_accum #(
    parameter int DATA_W = 14,
    parameter int ACC_LO = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sample_en,
    input  logic                           close,
    input  logic signed [DATA_W-1:0]       re,
    input  logic signed [DATA_W-1:0]       im,
    output logic [DATA_W-ACC_LO-1:0]       acc_next
);
    localparam int ACC_W = DATA_W - ACC_LO;

    logic [ACC_W-1:0] acc_q;

    // Absolute value; the most negative code is clamped to the largest positive one.
    function automatic logic [DATA_W-1:0] mag_sat(input logic signed [DATA_W-1:0] x);
        logic [DATA_W-1:0] most_neg;
        most_neg = {1'b1, {(DATA_W-1){1'b0}}};
        if (x == most_neg)
            return {1'b0, {(DATA_W-1){1'b1}}};
        else if (x[DATA_W-1])
            return DATA_W'(-x);
        else
            return x;
    endfunction

    // Bit i of the result is set when any magnitude bit at or above i+ACC_LO is set,
    // which fills ones below the leading one.
    function automatic logic [ACC_W-1:0] fill_down(input logic [DATA_W-1:0] m);
        logic [ACC_W-1:0] r;
        for (int i = 0; i < ACC_W; i++)
            r[i] = ((m >> (i + ACC_LO)) != '0);
        return r;
    endfunction

    always_comb begin
        acc_next = acc_q;
        if (sample_en)
            acc_next = acc_q | fill_down(mag_sat(re)) | fill_down(mag_sat(im));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else if (close)
            acc_q <= '0;
        else if (sample_en)
            acc_q <= acc_next;
    end
endmodule

// File: rtl/bfp_shift_pick.sv
`timescale 1ns/1ps
module bfp_shift_pick
    import bfp_pkg::*;
#(
    parameter int DATA_W  = 14,
    parameter int LOW_EXP = 11,
    parameter int ACC_LO  = 5
) (
    input  logic [DATA_W-ACC_LO-1:0] filled,
    output logic [SHIFT_W-1:0]       shift
);
    localparam int ACC_W  = DATA_W - ACC_LO;
    // Tree nodes, as positions inside the filled vector.
    localparam int N_ROOT = LOW_EXP - 3 - ACC_LO;
    localparam int N_HI   = LOW_EXP - 1 - ACC_LO;
    localparam int N_LO   = LOW_EXP - 5 - ACC_LO;
    localparam int L_TOP  = LOW_EXP - ACC_LO;
    localparam int L_2    = LOW_EXP - 2 - ACC_LO;
    localparam int L_4    = LOW_EXP - 4 - ACC_LO;
    localparam int L_6    = LOW_EXP - 6 - ACC_LO;

    logic at_bound;
    assign at_bound = |filled[ACC_W-1:L_TOP];

    always_comb begin
        if (filled[N_ROOT]) begin
            if (filled[N_HI])
                shift = at_bound       ? SHIFT_W'(0) : SHIFT_W'(1);
            else
                shift = filled[L_2]    ? SHIFT_W'(2) : SHIFT_W'(3);
        end else begin
            if (filled[N_LO])
                shift = filled[L_4]    ? SHIFT_W'(4) : SHIFT_W'(5);
            else
                shift = filled[L_6]    ? SHIFT_W'(6) : SHIFT_W'(7);
        end
    end
endmodule

// File: rtl/bfp_pingpong.sv
`timescale 1ns/1ps
module bfp_pingpong #(
    parameter int DATA_W  = 14,
    parameter int VEC_LEN = 8,
    parameter int IDX_W   = 3
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic                     wr_bank,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic signed [DATA_W-1:0] wr_re,
    input  logic signed [DATA_W-1:0] wr_im,
    input  logic                     rd_bank,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic signed [DATA_W-1:0] rd_re,
    output logic signed [DATA_W-1:0] rd_im
);
    logic signed [DATA_W-1:0] bank_re [2];
    logic signed [DATA_W-1:0] bank_im [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic signed [DATA_W-1:0] re_q [VEC_LEN];
        logic signed [DATA_W-1:0] im_q [VEC_LEN];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b))) begin
                re_q[wr_idx] <= wr_re;
                im_q[wr_idx] <= wr_im;
            end
        end

        assign bank_re[b] = re_q[rd_idx];
        assign bank_im[b] = im_q[rd_idx];
    end

    assign rd_re = bank_re[rd_bank];
    assign rd_im = bank_im[rd_bank];
endmodule

// File: rtl/bfp_vector_normalizer.sv
`timescale 1ns/1ps
module bfp_vector_normalizer
    import bfp_pkg::*;
#(
    parameter int DATA_W  = 14,
    parameter int VEC_LEN = 8,
    parameter int LOW_EXP = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_last,
    input  logic signed [DATA_W-1:0] in_re,
    input  logic signed [DATA_W-1:0] in_im,
    output logic                     out_valid,
    output logic                     out_last,
    output logic signed [DATA_W-1:0] out_re,
    output logic signed [DATA_W-1:0] out_im,
    output logic [SHIFT_W-1:0]       out_shift
);
    localparam int IDX_W  = (VEC_LEN > 1) ? $clog2(VEC_LEN) : 1;
    localparam int ACC_LO = LOW_EXP - MAX_SHIFT + 1;
    localparam int ACC_W  = DATA_W - ACC_LO;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(VEC_LEN - 1);

    bfp_state_e state_q, state_d;

    logic               close;
    logic               play_end;
    logic [IDX_W-1:0]   wr_idx_q;
    logic               wr_bank_q;
    logic [IDX_W-1:0]   rd_idx_q;
    logic               rd_bank_q;
    logic [SHIFT_W-1:0] shift_q;
    logic [SHIFT_W-1:0] pick_shift;
    logic [ACC_W-1:0]   acc_next;
    logic signed [DATA_W-1:0] rd_re, rd_im;

    assign close    = in_valid & in_last;
    assign play_end = (state_q == ST_PLAY) && (rd_idx_q == LAST_IDX);

    bfp_mag_accum #(.DATA_W(DATA_W), .ACC_LO(ACC_LO)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (in_valid),
        .close     (close),
        .re        (in_re),
        .im        (in_im),
        .acc_next  (acc_next)
    );

    bfp_shift_pick #(.DATA_W(DATA_W), .LOW_EXP(LOW_EXP), .ACC_LO(ACC_LO)) u_pick (
        .filled (acc_next),
        .shift  (pick_shift)
    );

    bfp_pingpong #(.DATA_W(DATA_W), .VEC_LEN(VEC_LEN), .IDX_W(IDX_W)) u_buf (
        .clk     (clk),
        .wr_en   (in_valid),
        .wr_bank (wr_bank_q),
        .wr_idx  (wr_idx_q),
        .wr_re   (in_re),
        .wr_im   (in_im),
        .rd_bank (rd_bank_q),
        .rd_idx  (rd_idx_q),
        .rd_re   (rd_re),
        .rd_im   (rd_im)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Transitions: vector closed (IDLE->PLAY, PLAY->PLAY restart), drained (PLAY->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (close) state_d = ST_PLAY;
            ST_PLAY: begin
                if (close)
                    state_d = ST_PLAY;
                else if (play_end)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Write and playback pointers, applied shift
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_idx_q  <= '0;
            wr_bank_q <= 1'b0;
            rd_idx_q  <= '0;
            rd_bank_q <= 1'b0;
            shift_q   <= '0;
        end else begin
            if (in_valid) begin
                if (in_last) begin
                    wr_idx_q  <= '0;
                    wr_bank_q <= ~wr_bank_q;
                end else begin
                    wr_idx_q  <= (wr_idx_q == LAST_IDX) ? '0 : wr_idx_q + 1'b1;
                end
            end
            if (close) begin
                rd_bank_q <= wr_bank_q;
                rd_idx_q  <= '0;
                shift_q   <= pick_shift;
            end else if (state_q == ST_PLAY) begin
                rd_idx_q  <= play_end ? '0 : rd_idx_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        out_valid = 1'b0;
        out_last  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PLAY: begin
                out_valid = 1'b1;
                out_last  = play_end;
            end
            default: ;
        endcase
        out_re    = rd_re <<< shift_q;
        out_im    = rd_im <<< shift_q;
        out_shift = shift_q;
    end
endmodule

// File: rtl/bfp_normalizer_chk.sv
`timescale 1ns/1ps
module bfp_normalizer_chk
    import bfp_pkg::*;
#(
    parameter int DATA_W  = 14,
    parameter int LOW_EXP = 11
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     in_last,
    input logic                     out_valid,
    input logic                     out_last,
    input logic signed [DATA_W-1:0] out_re,
    input logic signed [DATA_W-1:0] out_im,
    input logic [SHIFT_W-1:0]       out_shift
);
    localparam int LIM = 1 << (LOW_EXP + 1);

    // R1
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R7
    start_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> out_valid);

    // R7
    play_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid);

    // R5
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> $stable(out_shift));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_shift != '0) |->
            (out_re < LIM && out_re >= -LIM && out_im < LIM && out_im >= -LIM));
endmodule

bind bfp_vector_normalizer bfp_normalizer_chk #(.DATA_W(DATA_W), .LOW_EXP(LOW_EXP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_re    (out_re),
    .out_im    (out_im),
    .out_shift (out_shift)
);

// File: tb/tb_bfp_vector_normalizer.sv
`timescale 1ns/1ps
module tb_bfp_vector_normalizer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic signed [13:0] in_re = '0, in_im = '0;
    logic out_valid, out_last;
    logic signed [13:0] out_re, out_im;
    logic [2:0] out_shift;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic signed [13:0] vre [2][8];
    logic signed [13:0] vim [2][8];

    always #2.5 clk = ~clk;

    bfp_vector_normalizer dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_last(out_last),
        .out_re(out_re), .out_im(out_im), .out_shift(out_shift)
    );

    function automatic int absv(input logic signed [13:0] x);
        if (x == -14'sd8192) return 8191;
        return (x < 0) ? -int'(x) : int'(x);
    endfunction

    // Expected shift: smallest s (capped at 7) lifting the peak to 2048 or more
    function automatic int exp_shift(input int b);
        int mx = 0;
        int s = 0;
        for (int k = 0; k < 8; k++) begin
            if (absv(vre[b][k]) > mx) mx = absv(vre[b][k]);
            if (absv(vim[b][k]) > mx) mx = absv(vim[b][k]);
        end
        while (s < 7 && (mx << s) < 2048) s++;
        return s;
    endfunction

    // Peak magnitude mx at re[3] (or im[5]); all other parts are smaller
    task automatic fill_vec(input int b, input int mx, input bit im_lead);
        for (int k = 0; k < 8; k++) begin
            int v = (mx * k) / 9;
            int w = (mx * (7 - k)) / 9;
            vre[b][k] = 14'((k % 2) ? -v : v);
            vim[b][k] = 14'((k % 3 == 0) ? -w : w);
        end
        if (im_lead) vim[b][5] = 14'(-mx);
        else         vre[b][3] = 14'(mx);
    endtask

    task automatic drive_vec(input int b, input int gap_at);
        for (int k = 0; k < 8; k++) begin
            if (k == gap_at) begin
                @(negedge clk);
                in_valid = 1'b0; in_last = 1'b1;
                in_re = -14'sd8192; in_im = 14'sd8191;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_last  = (k == 7);
            in_re    = vre[b][k];
            in_im    = vim[b][k];
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_re = '0; in_im = '0;
    endtask

    task automatic check_vec(input int b, input string tag);
        int s = exp_shift(b);
        for (int k = 0; k < 8; k++) begin
            logic signed [13:0] er, ei;
            @(negedge clk);
            er = vre[b][k] <<< s;
            ei = vim[b][k] <<< s;
            n_checks++;
            if (out_valid !== 1'b1 || out_last !== (k == 7) || out_shift !== 3'(s) ||
                out_re !== er || out_im !== ei) begin
                n_fail++;
                $display("FAIL %s elem %0d: valid=%0b last=%0b shift=%0d re=%0d im=%0d; expected valid=1 last=%0b shift=%0d re=%0d im=%0d",
                         tag, k, out_valid, out_last, out_shift, out_re, out_im,
                         (k == 7), s, er, ei);
            end
        end
    endtask

    task automatic check_idle(input string tag);
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_last !== 1'b0) begin
            n_fail++;
            $display("FAIL %s: valid=%0b last=%0b; expected valid=0 last=0", tag, out_valid, out_last);
        end
    endtask

    task automatic run_single(input int b, input string tag);
        drive_vec(b, -1);
        fork
            go_idle();
            check_vec(b, tag);
        join
        check_idle({tag, " R7 no extra element"});
    endtask

    // R1
    task automatic test_reset();
        repeat (3) @(negedge clk);
        check_idle("R1 during reset");
        rst_n = 1'b1;
        check_idle("R1 after release");
        check_idle("R1 after release");
    endtask

    // R2, R5
    task automatic test_large();
        fill_vec(0, 3000, 0);   run_single(0, "R2 peak 3000");
        fill_vec(0, 2048, 1);   run_single(0, "R2 peak 2048");
        fill_vec(0, 8191, 0);   run_single(0, "R2 peak 8191");
    endtask

    // R3, R5
    task automatic test_ladder();
        for (int k = 5; k <= 10; k++) begin
            fill_vec(0, (1 << k) + (1 << k) / 3, k % 2);
            run_single(0, $sformatf("R3 msb bit %0d", k));
            fill_vec(0, (1 << k), 0);
            run_single(0, $sformatf("R3 power of two bit %0d", k));
        end
    endtask

    // R4
    task automatic test_small();
        fill_vec(0, 31, 0);  run_single(0, "R4 peak 31");
        fill_vec(0, 0, 0);   run_single(0, "R4 all zero");
        fill_vec(0, 1, 1);   run_single(0, "R4 peak 1");
    endtask

    // R6
    task automatic test_negative();
        fill_vec(0, 700, 1);  run_single(0, "R6 negative imaginary peak");
        fill_vec(0, 40, 0);
        vre[0][0] = -14'sd8192;
        run_single(0, "R6 most negative code");
        fill_vec(0, 50, 0);
        vim[0][2] = -14'sd1500;
        run_single(0, "R6 imaginary sets peak");
    endtask

    // R8, R9
    task automatic test_back_to_back();
        fill_vec(0, 5000, 0);
        fill_vec(1, 20, 1);
        drive_vec(0, -1);
        fork
            drive_vec(1, -1);
            check_vec(0, "R9 first of pair");
        join
        fork
            go_idle();
            check_vec(1, "R8 second of pair");
        join
        check_idle("R9 after pair");
    endtask

    // R10
    task automatic test_gap();
        fill_vec(0, 100, 0);
        drive_vec(0, 4);
        fork
            go_idle();
            check_vec(0, "R10 gap ignored");
        join
        check_idle("R10 after gap vector");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_large();
        test_ladder();
        test_small();
        test_negative();
        test_back_to_back();
        test_gap();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule